// File: doc/BRIEF.md
# Register Rename Status Table

This block is a small floating-point register file for an out-of-order issue engine. Each register holds a data value, a pending flag and a 4-bit producer tag. When an operation is issued, the block returns the state of its two source registers. A ready source returns its value. A pending source returns the tag of the unit that will produce it. In the same issue, the block claims the destination register for the issuing station: it marks the register pending and stores that station's tag there. Tag value 0 is reserved to mean "no producer".

A result broadcast bus is snooped every cycle. A pending register captures the broadcast value, and becomes ready, only when its stored tag equals the broadcast tag. A destination claim always replaces any older tag, so only the most recent producer can ever fill the register. Results from superseded producers fall away. This is what removes write-after-read and write-after-write hazards. A test write port preloads register values.

Top module: `rename_status_table`

## Requirements
- R1: After reset every register reads as ready (pending flag 0), with tag 0 and value 0.
- R2: A test write loads the value into the selected register and leaves it ready with tag 0. It takes precedence over a matching broadcast to the same register in the same cycle.
- R3: An issue with `iss_wr_en` set and a nonzero `iss_tag` makes the destination pending, with tag `iss_tag`, from the next cycle. Any earlier pending tag is replaced.
- R4: An issue with `iss_tag` equal to 0 does not change any register.
- R5: Each read port is combinational and reflects the current state of the register it selects. For a ready register it shows a pending flag of 0, a tag of 0 and the stored value. For a pending register it shows a pending flag of 1, the pending tag and the stored value.
- R6: When a source register is also the destination of the same issue and is ready, the read port returns the old value as ready in that cycle. The register becomes pending only from the next cycle.
- R7: A pending register whose tag equals the tag of a valid broadcast takes the broadcast data and becomes ready with tag 0 from the next cycle.
- R8: A broadcast is applied before an issue in the same cycle. A read port whose register matches the broadcast returns the broadcast data as ready. An issue to that register leaves it pending with the new tag, holding the broadcast data.
- R9: A broadcast leaves a register unchanged in any of these cases: the broadcast is not valid, the register is ready, or the broadcast tag differs from the register's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue slot carries an operation |
| iss_wr_en | input | 1 | Operation writes a destination register |
| iss_dst | input | IDX_W | Destination register index |
| iss_tag | input | 4 | Tag of the issuing station (0 means none) |
| src_a | input | IDX_W | Register selected by read port A |
| src_b | input | IDX_W | Register selected by read port B |
| a_busy | output | 1 | Port A register is pending |
| a_tag | output | 4 | Port A pending tag, 0 when ready |
| a_data | output | DATA_W | Port A value |
| b_busy | output | 1 | Port B register is pending |
| b_tag | output | 4 | Port B pending tag, 0 when ready |
| b_data | output | DATA_W | Port B value |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | 4 | Tag of the broadcasting producer |
| bc_data | input | DATA_W | Broadcast result value |
| tw_en | input | 1 | Test write enable |
| tw_idx | input | IDX_W | Test write register index |
| tw_data | input | DATA_W | Test write value |

## Verification
The assertions check on every cycle the rules for each register:
- a claim sets the pending flag and the tag;
- a pending register never holds tag 0;
- a matching broadcast fills the register and clears its pending flag;
- a register that nothing selected keeps its state;
- port A forwards a matching broadcast in the same cycle.

Some behaviours involve ordering across several operations, and only the bench scenarios show them: a stale producer's result dropped after a newer claim, an issue that reads and claims the same register, a broadcast and a claim to one register in the same cycle, and a test write beating a broadcast. A behavioural model covers these, along with random traffic, and is compared on both read ports on every clock.

// File: rtl/rntab_pkg.sv
package rntab_pkg;

  localparam int unsigned TAG_W = 4;

  typedef logic [TAG_W-1:0] tag_t;

  localparam tag_t NULL_TAG = '0;

  // A pending register accepts a broadcast only from its own current producer.
  function automatic logic tag_capture(input logic busy, input tag_t cur,
                                       input logic bv, input tag_t bt);
    return busy && bv && (cur == bt);
  endfunction

  // Tag shown on a read port: the producer if still pending, otherwise none.
  function automatic tag_t shown_tag(input logic pending, input tag_t cur);
    return pending ? cur : NULL_TAG;
  endfunction

endpackage

// File: rtl/rntab_entry.sv
module rntab_entry
  import rntab_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tw_sel,
  input  logic [DATA_W-1:0] tw_data,
  input  logic              bc_valid,
  input  tag_t              bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              iss_sel,
  input  tag_t              iss_tag,
  output logic [DATA_W-1:0] q_val,
  output logic              q_busy,
  output tag_t              q_tag,
  output logic              hit
);

  logic [DATA_W-1:0] n_val;
  logic              n_busy;
  tag_t              n_tag;

  assign hit = tag_capture(q_busy, q_tag, bc_valid, bc_tag);

  // Order inside one cycle: test write, then broadcast, then issue claim.
  always_comb begin
    n_val  = q_val;
    n_busy = q_busy;
    n_tag  = q_tag;
    if (tw_sel) begin
      n_val  = tw_data;
      n_busy = 1'b0;
      n_tag  = NULL_TAG;
    end else if (hit) begin
      n_val  = bc_data;
      n_busy = 1'b0;
      n_tag  = NULL_TAG;
    end
    if (iss_sel) begin
      n_busy = 1'b1;
      n_tag  = iss_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_val  <= '0;
      q_busy <= 1'b0;
      q_tag  <= NULL_TAG;
    end else begin
      q_val  <= n_val;
      q_busy <= n_busy;
      q_tag  <= n_tag;
    end
  end

endmodule

// File: rtl/rntab_read_port.sv
module rntab_read_port
  import rntab_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [IDX_W-1:0]           sel,
  input  logic [NUM_REGS*DATA_W-1:0] vals_flat,
  input  logic [NUM_REGS*TAG_W-1:0]  tags_flat,
  input  logic [NUM_REGS-1:0]        busy_vec,
  input  logic [NUM_REGS-1:0]        hit_vec,
  input  logic [DATA_W-1:0]          bc_data,
  output logic                       r_busy,
  output tag_t                       r_tag,
  output logic [DATA_W-1:0]          r_data
);

  logic              sel_hit;
  logic              sel_busy;
  tag_t              sel_tag;
  logic [DATA_W-1:0] sel_val;

  always_comb begin
    sel_hit  = hit_vec[sel];
    sel_busy = busy_vec[sel];
    sel_tag  = tags_flat[sel*TAG_W +: TAG_W];
    sel_val  = vals_flat[sel*DATA_W +: DATA_W];
    // A broadcast in this cycle is visible to the reader before any claim.
    r_busy   = sel_busy && !sel_hit;
    r_tag    = shown_tag(r_busy, sel_tag);
    r_data   = sel_hit ? bc_data : sel_val;
  end

endmodule

// File: rtl/rename_status_table.sv
module rename_status_table
  import rntab_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic              iss_wr_en,
  input  logic [IDX_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic [IDX_W-1:0]  src_a,
  input  logic [IDX_W-1:0]  src_b,
  output logic              a_busy,
  output logic [TAG_W-1:0]  a_tag,
  output logic [DATA_W-1:0] a_data,
  output logic              b_busy,
  output logic [TAG_W-1:0]  b_tag,
  output logic [DATA_W-1:0] b_data,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              tw_en,
  input  logic [IDX_W-1:0]  tw_idx,
  input  logic [DATA_W-1:0] tw_data
);

  // Named internal events, brought out for the checker.
  logic                       iss_fire;
  logic [NUM_REGS-1:0]        iss_sel;
  logic [NUM_REGS-1:0]        tw_sel;
  logic [NUM_REGS-1:0]        bc_hit;
  logic [NUM_REGS-1:0]        busy_vec;
  logic [NUM_REGS*TAG_W-1:0]  tags_flat;
  logic [NUM_REGS*DATA_W-1:0] vals_flat;

  assign iss_fire = iss_valid && iss_wr_en && (iss_tag != NULL_TAG);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign iss_sel[i] = iss_fire && (iss_dst == IDX_W'(i));
    assign tw_sel[i]  = tw_en && (tw_idx == IDX_W'(i));

    rntab_entry #(.DATA_W(DATA_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .tw_sel   (tw_sel[i]),
      .tw_data  (tw_data),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .bc_data  (bc_data),
      .iss_sel  (iss_sel[i]),
      .iss_tag  (iss_tag),
      .q_val    (vals_flat[i*DATA_W +: DATA_W]),
      .q_busy   (busy_vec[i]),
      .q_tag    (tags_flat[i*TAG_W +: TAG_W]),
      .hit      (bc_hit[i])
    );
  end

  rntab_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .sel       (src_a),
    .vals_flat (vals_flat),
    .tags_flat (tags_flat),
    .busy_vec  (busy_vec),
    .hit_vec   (bc_hit),
    .bc_data   (bc_data),
    .r_busy    (a_busy),
    .r_tag     (a_tag),
    .r_data    (a_data)
  );

  rntab_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .sel       (src_b),
    .vals_flat (vals_flat),
    .tags_flat (tags_flat),
    .busy_vec  (busy_vec),
    .hit_vec   (bc_hit),
    .bc_data   (bc_data),
    .r_busy    (b_busy),
    .r_tag     (b_tag),
    .r_data    (b_data)
  );

endmodule

// File: rtl/rntab_checker.sv
module rntab_checker
  import rntab_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 32,
  localparam int unsigned IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_REGS-1:0]        iss_sel,
  input logic [TAG_W-1:0]           iss_tag,
  input logic [NUM_REGS-1:0]        tw_sel,
  input logic [DATA_W-1:0]          bc_data,
  input logic [NUM_REGS-1:0]        bc_hit,
  input logic [NUM_REGS-1:0]        busy_vec,
  input logic [NUM_REGS*TAG_W-1:0]  tags_flat,
  input logic [NUM_REGS*DATA_W-1:0] vals_flat,
  input logic [IDX_W-1:0]           src_a,
  input logic                       a_busy,
  input logic [DATA_W-1:0]          a_data
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_chk
    AST_CLAIM_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
      iss_sel[i] |=> busy_vec[i] && (tags_flat[i*TAG_W +: TAG_W] == $past(iss_tag))); // R3

    AST_PENDING_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      busy_vec[i] |-> (tags_flat[i*TAG_W +: TAG_W] != NULL_TAG)); // R4

    AST_MATCH_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_hit[i] && !iss_sel[i] && !tw_sel[i]) |=>
        (!busy_vec[i] && (vals_flat[i*DATA_W +: DATA_W] == $past(bc_data)))); // R7

    AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bc_hit[i] && !iss_sel[i] && !tw_sel[i]) |=>
        ($stable(busy_vec[i]) && $stable(tags_flat[i*TAG_W +: TAG_W]) &&
         $stable(vals_flat[i*DATA_W +: DATA_W]))); // R9

    AST_TEST_WRITE_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (tw_sel[i] && !iss_sel[i]) |=> !busy_vec[i]); // R2
  end

  AST_READ_FORWARDS: assert property (@(posedge clk) disable iff (!rst_n)
    bc_hit[src_a] |-> (!a_busy && (a_data == bc_data))); // R8

endmodule

bind rename_status_table rntab_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_sel   (iss_sel),
  .iss_tag   (iss_tag),
  .tw_sel    (tw_sel),
  .bc_data   (bc_data),
  .bc_hit    (bc_hit),
  .busy_vec  (busy_vec),
  .tags_flat (tags_flat),
  .vals_flat (vals_flat),
  .src_a     (src_a),
  .a_busy    (a_busy),
  .a_data    (a_data)
);

// File: tb/rename_status_table_tb.sv
module rename_status_table_tb;

  localparam int NR = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iss_valid = 0, iss_wr_en = 0;
  logic [1:0]    iss_dst = 0, src_a = 0, src_b = 0, tw_idx = 0;
  logic [3:0]    iss_tag = 0, bc_tag = 0;
  logic          bc_valid = 0, tw_en = 0;
  logic [DW-1:0] bc_data = 0, tw_data = 0;
  logic          a_busy, b_busy;
  logic [3:0]    a_tag, b_tag;
  logic [DW-1:0] a_data, b_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model state
  int          m_busy [NR];
  int          m_tag  [NR];
  logic [DW-1:0] m_val [NR];

  always #5 clk = ~clk;

  rename_status_table u_dut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iss_valid), .iss_wr_en(iss_wr_en), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .src_a(src_a), .src_b(src_b),
    .a_busy(a_busy), .a_tag(a_tag), .a_data(a_data),
    .b_busy(b_busy), .b_tag(b_tag), .b_data(b_data),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
    .tw_en(tw_en), .tw_idx(tw_idx), .tw_data(tw_data)
  );

  task automatic idle();
    iss_valid = 0; iss_wr_en = 0; iss_dst = 0; iss_tag = 0;
    bc_valid = 0; bc_tag = 0; bc_data = 0; tw_en = 0; tw_idx = 0; tw_data = 0;
  endtask

  task automatic cmp_port(input string req, input string nm, input int s,
                          input logic busy, input logic [3:0] tag, input logic [DW-1:0] data);
    int eb, et;
    logic [DW-1:0] ed;
    bit hit;
    hit = bc_valid && (m_busy[s] != 0) && (m_tag[s] == int'(bc_tag));
    eb  = (m_busy[s] != 0 && !hit) ? 1 : 0;
    et  = eb ? m_tag[s] : 0;
    ed  = hit ? bc_data : m_val[s];
    checks++;
    if (int'(busy) != eb || int'(tag) != et || data !== ed) begin
      errors++;
      $display("FAIL %s port %s reg %0d: got busy=%0d tag=%0d data=%h, exp busy=%0d tag=%0d data=%h",
               req, nm, s, busy, tag, data, eb, et, ed);
    end
  endtask

  // Compare both read ports, then clock once and advance the model.
  task automatic tick(input string req);
    #1;
    cmp_port(req, "A", int'(src_a), a_busy, a_tag, a_data);
    cmp_port(req, "B", int'(src_b), b_busy, b_tag, b_data);
    @(posedge clk);
    for (int r = 0; r < NR; r++) begin
      if (tw_en && int'(tw_idx) == r) begin
        m_val[r] = tw_data; m_busy[r] = 0; m_tag[r] = 0;
      end else if (bc_valid && m_busy[r] != 0 && m_tag[r] == int'(bc_tag)) begin
        m_val[r] = bc_data; m_busy[r] = 0; m_tag[r] = 0;
      end
      if (iss_valid && iss_wr_en && iss_tag != 0 && int'(iss_dst) == r) begin
        m_busy[r] = 1; m_tag[r] = int'(iss_tag);
      end
    end
    @(negedge clk);
  endtask

  task automatic look(input string req, input int ra, input int rb);
    idle();
    src_a = 2'(ra); src_b = 2'(rb);
    tick(req);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    for (int r = 0; r < NR; r++) begin m_busy[r] = 0; m_tag[r] = 0; m_val[r] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1: reset state
    look("R1", 0, 1);
    look("R1", 2, 3);

    // R2: preload all registers
    for (int r = 0; r < NR; r++) begin
      idle(); tw_en = 1; tw_idx = 2'(r); tw_data = 32'h1000 + r;
      tick("R2");
    end
    look("R2", 0, 1);
    look("R2", 2, 3);

    // R6: read and claim the same ready register
    idle(); src_a = 1; src_b = 1; iss_valid = 1; iss_wr_en = 1; iss_dst = 1; iss_tag = 4'd10;
    tick("R6");
    look("R5", 1, 0);

    // R3: newer claim replaces pending tag
    idle(); src_a = 1; iss_valid = 1; iss_wr_en = 1; iss_dst = 1; iss_tag = 4'd11;
    tick("R3");
    look("R3", 1, 1);

    // R9: superseded producer's result dropped; invalid bus and ready registers untouched
    idle(); src_a = 1; src_b = 0; bc_valid = 1; bc_tag = 4'd10; bc_data = 32'hDEAD0010;
    tick("R9");
    look("R9", 1, 0);
    idle(); src_a = 1; bc_valid = 0; bc_tag = 4'd11; bc_data = 32'hBAD0BAD0;
    tick("R9");
    look("R9", 1, 2);

    // R8: broadcast and claim on the same register in one cycle
    idle(); src_a = 1; src_b = 1; bc_valid = 1; bc_tag = 4'd11; bc_data = 32'hCAFE0011;
    iss_valid = 1; iss_wr_en = 1; iss_dst = 1; iss_tag = 4'd12;
    tick("R8");
    look("R8", 1, 1);

    // R7: matching broadcast fills the register
    idle(); src_a = 0; bc_valid = 1; bc_tag = 4'd12; bc_data = 32'hFEED0012;
    tick("R7");
    look("R7", 1, 0);

    // R4: tag 0 claim has no effect; R3 write disabled has none either
    idle(); iss_valid = 1; iss_wr_en = 1; iss_dst = 2; iss_tag = 4'd0;
    tick("R4");
    look("R4", 2, 2);
    idle(); iss_valid = 1; iss_wr_en = 0; iss_dst = 2; iss_tag = 4'd7;
    tick("R3");
    look("R3", 2, 3);

    // R2: test write beats a matching broadcast
    idle(); iss_valid = 1; iss_wr_en = 1; iss_dst = 3; iss_tag = 4'd5;
    tick("R3");
    idle(); src_a = 3; tw_en = 1; tw_idx = 3; tw_data = 32'h5A5A0003;
    bc_valid = 1; bc_tag = 4'd5; bc_data = 32'h77770005;
    tick("R2");
    look("R2", 3, 3);

    // R5: random traffic against the model
    for (int n = 0; n < 600; n++) begin
      idle();
      src_a     = 2'($urandom_range(0, 3));
      src_b     = 2'($urandom_range(0, 3));
      iss_valid = 1'($urandom_range(0, 1));
      iss_wr_en = 1'($urandom_range(0, 3) != 0);
      iss_dst   = 2'($urandom_range(0, 3));
      iss_tag   = 4'($urandom_range(0, 6));
      bc_valid  = 1'($urandom_range(0, 1));
      bc_tag    = 4'($urandom_range(1, 6));
      bc_data   = 32'($urandom);
      tw_en     = 1'($urandom_range(0, 7) == 0);
      tw_idx    = 2'($urandom_range(0, 3));
      tw_data   = 32'($urandom);
      tick("R5");
    end
    summary();
  end

endmodule